// File: doc/BRIEF.md
# USB High-Speed Chirp Handshake Sequencer

This block is the device-side controller that runs after a bus reset and decides whether the link comes up at high speed or stays at full speed. It watches the two-bit line state that the transceiver reports and waits for a single-ended zero that lasts long enough to count as a reset. It then asks a register-access port to write the transceiver configuration. Once that write is acknowledged, it raises a chirp-K transmit enable for a fixed number of microsecond ticks. After that it listens for the host's alternating K and J chirps.

If the host answers with enough K-to-J pairs before the listening window closes, the block writes the normal high-speed configuration and reports high speed. If the window closes first, it writes the full-speed configuration and reports full speed. After a failed handshake it does not chirp again until the line has left SE0. A parameter can remove high-speed capability entirely; the block then never leaves full speed.

All timing is counted in ticks of a one-microsecond strobe. Configuration writes hold their request and field values until the register port acknowledges them. An access that is lost or aborted is therefore retried simply by waiting.

Top module: `chirp_seq`

## Requirements
- R1: While reset is high and in the cycle after it, reg_wr_req, chirp_tx_en and speed_hs are 0, and the field outputs show full-speed settings: reg_xcvr_sel=01, reg_term_sel=1, reg_op_mode=00.
- R2: line_state encodes 00 as SE0, 01 as J (D+ high) and 10 as K (D- high). A reset is recognised only after SE0 has been held continuously for SE0_MIN_US ticks of us_tick. A shorter SE0, or SE0 held without ticks, starts nothing.
- R3: A recognised reset raises reg_wr_req with reg_xcvr_sel=00, reg_term_sel=1 and reg_op_mode=10 (chirp). The request and fields stay unchanged until reg_ack is seen.
- R4: chirp_tx_en rises only in the cycle after that chirp configuration write is acknowledged. It stays high for at least CHIRP_K_US ticks and at most one tick more. reg_wr_req is never high while chirp_tx_en is high.
- R5: If KJ_PAIRS K-to-J transitions arrive within HOST_WAIT_US ticks after the chirp, the block requests reg_xcvr_sel=00, reg_term_sel=0 and reg_op_mode=00. After the acknowledgement it holds speed_hs=1 until reset.
- R6: If the window expires first, the block requests reg_xcvr_sel=01, reg_term_sel=1 and reg_op_mode=00. speed_hs then stays 0, and no new request or chirp starts while SE0 persists.
- R7: When the last K-J pair completes in the same cycle that the listening window expires, high speed wins.
- R8: With HS_CAPABLE=0, reg_wr_req, chirp_tx_en and speed_hs stay 0 whatever the line does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_state | input | 2 | Line state from the transceiver (00 SE0, 01 J, 10 K) |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| reg_ack | input | 1 | Register port has completed the pending write |
| reg_wr_req | output | 1 | Configuration write request, held until acknowledged |
| reg_xcvr_sel | output | 2 | Transceiver-select field value to write |
| reg_term_sel | output | 1 | Termination-select field value to write |
| reg_op_mode | output | 2 | Operating-mode field value to write |
| chirp_tx_en | output | 1 | Transmit chirp K |
| speed_hs | output | 1 | 1 once high speed is negotiated |

## Verification
Two functions can land in the same cycle: the expiry of the host-listening window, and the completion of the last K-J pair. The bench times the host chirps from the falling edge of chirp_tx_en. In one case the final J is placed so that both events fall on the same clock. In the other it arrives one cycle later. The first case must end in the high-speed write and the second in the full-speed write. The field values of the resulting request, together with speed_hs after the acknowledgement, show which branch was taken.

// File: rtl/chirp_seq_pkg.sv
package chirp_seq_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG_CHIRP,
        ST_CHIRP_K,
        ST_WAIT_HOST,
        ST_CFG_HS,
        ST_HS,
        ST_CFG_FS,
        ST_FS_HOLD
    } seq_state_t;

    typedef struct packed {
        logic [1:0] xcvr;
        logic       term;
        logic [1:0] opmode;
    } phy_cfg_t;

    localparam logic [1:0] XCVR_HS    = 2'b00;
    localparam logic [1:0] XCVR_FS    = 2'b01;
    localparam logic [1:0] OPM_NORMAL = 2'b00;
    localparam logic [1:0] OPM_CHIRP  = 2'b10;

    function automatic phy_cfg_t cfg_for(seq_state_t s);
        phy_cfg_t c;
        case (s)
            ST_CFG_CHIRP, ST_CHIRP_K, ST_WAIT_HOST:
                c = '{xcvr: XCVR_HS, term: 1'b1, opmode: OPM_CHIRP};
            ST_CFG_HS, ST_HS:
                c = '{xcvr: XCVR_HS, term: 1'b0, opmode: OPM_NORMAL};
            default:
                c = '{xcvr: XCVR_FS, term: 1'b1, opmode: OPM_NORMAL};
        endcase
        return c;
    endfunction

    function automatic logic is_cfg_state(seq_state_t s);
        return (s == ST_CFG_CHIRP) || (s == ST_CFG_HS) || (s == ST_CFG_FS);
    endfunction

endpackage

// File: rtl/chirp_us_timer.sv
module chirp_us_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick && !done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/chirp_se0_qual.sv
module chirp_se0_qual
    import chirp_seq_pkg::*;
#(
    parameter int MIN_US = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] line_state,
    input  logic       tick,
    output logic       qualified
);
    localparam int CW = $clog2(MIN_US + 1);

    logic [CW-1:0] cnt;
    logic          is_se0;

    assign is_se0    = (line_state == LS_SE0);
    assign qualified = is_se0 && (cnt == CW'(MIN_US));

    always_ff @(posedge clk) begin
        if (rst || !is_se0) begin
            cnt <= '0;
        end else if (tick && (cnt != CW'(MIN_US))) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/chirp_kj_count.sv
module chirp_kj_count
    import chirp_seq_pkg::*;
#(
    parameter int PAIRS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] line_state,
    output logic       done
);
    localparam int PW = $clog2(PAIRS + 1);

    logic [PW-1:0] pairs;
    logic          saw_k;

    assign done = (pairs == PW'(PAIRS));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pairs <= '0;
            saw_k <= 1'b0;
        end else if (line_state == LS_K) begin
            saw_k <= 1'b1;
        end else if (line_state == LS_J && saw_k) begin
            saw_k <= 1'b0;
            if (!done) begin
                pairs <= pairs + 1'b1;
            end
        end
    end
endmodule

// File: rtl/chirp_seq.sv
module chirp_seq
    import chirp_seq_pkg::*;
#(
    parameter bit HS_CAPABLE   = 1'b1,
    parameter int SE0_MIN_US   = 3,
    parameter int CHIRP_K_US   = 1000,
    parameter int HOST_WAIT_US = 2500,
    parameter int KJ_PAIRS     = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] line_state,
    input  logic       us_tick,
    input  logic       reg_ack,
    output logic       reg_wr_req,
    output logic [1:0] reg_xcvr_sel,
    output logic       reg_term_sel,
    output logic [1:0] reg_op_mode,
    output logic       chirp_tx_en,
    output logic       speed_hs
);
    localparam int TMAX = (CHIRP_K_US > HOST_WAIT_US) ? CHIRP_K_US : HOST_WAIT_US;
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_t  st, st_nx;
    logic        se0_ok, tmr_done, tmr_clr, pairs_ok;
    logic [TW-1:0] tmr_limit;
    phy_cfg_t    cfg;

    generate
        if (HS_CAPABLE) begin : g_hs
            chirp_se0_qual #(.MIN_US(SE0_MIN_US)) u_se0 (
                .clk       (clk),
                .rst       (rst),
                .line_state(line_state),
                .tick      (us_tick),
                .qualified (se0_ok)
            );
        end else begin : g_fs_only
            assign se0_ok = 1'b0;
        end
    endgenerate

    chirp_us_timer #(.W(TW)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .tick (us_tick),
        .limit(tmr_limit),
        .done (tmr_done)
    );

    chirp_kj_count #(.PAIRS(KJ_PAIRS)) u_kj (
        .clk       (clk),
        .rst       (rst),
        .en        (st == ST_WAIT_HOST),
        .line_state(line_state),
        .done      (pairs_ok)
    );

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:      if (se0_ok) st_nx = ST_CFG_CHIRP;
            ST_CFG_CHIRP: if (reg_ack) st_nx = ST_CHIRP_K;
            ST_CHIRP_K:   if (tmr_done) st_nx = ST_WAIT_HOST;
            ST_WAIT_HOST: begin
                if (pairs_ok)      st_nx = ST_CFG_HS;
                else if (tmr_done) st_nx = ST_CFG_FS;
            end
            ST_CFG_HS:    if (reg_ack) st_nx = ST_HS;
            ST_HS:        st_nx = ST_HS;
            ST_CFG_FS:    if (reg_ack) st_nx = ST_FS_HOLD;
            ST_FS_HOLD:   if (line_state != LS_SE0) st_nx = ST_IDLE;
            default:      st_nx = ST_IDLE;
        endcase
    end

    assign tmr_clr   = (st_nx != st);
    assign tmr_limit = (st == ST_WAIT_HOST) ? TW'(HOST_WAIT_US) : TW'(CHIRP_K_US);

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    assign cfg          = cfg_for(st);
    assign reg_xcvr_sel = cfg.xcvr;
    assign reg_term_sel = cfg.term;
    assign reg_op_mode  = cfg.opmode;
    assign reg_wr_req   = is_cfg_state(st);
    assign chirp_tx_en  = (st == ST_CHIRP_K);
    assign speed_hs     = (st == ST_HS);
endmodule

// File: rtl/chirp_seq_checker.sv
module chirp_seq_checker #(
    parameter bit HS_CAPABLE = 1'b1,
    parameter int CHIRP_K_US = 1000
) (
    input logic       clk,
    input logic       rst,
    input logic       us_tick,
    input logic       reg_ack,
    input logic       reg_wr_req,
    input logic [1:0] reg_xcvr_sel,
    input logic       reg_term_sel,
    input logic [1:0] reg_op_mode,
    input logic       chirp_tx_en,
    input logic       speed_hs
);
    int chirp_ticks;

    always_ff @(posedge clk) begin
        if (rst || !chirp_tx_en) chirp_ticks <= 0;
        else if (us_tick)        chirp_ticks <= chirp_ticks + 1;
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_req && !reg_ack) |=>
            (reg_wr_req && $stable({reg_xcvr_sel, reg_term_sel, reg_op_mode})));

    assert_chirp_after_cfg_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(chirp_tx_en) |->
            $past(reg_wr_req && reg_ack && reg_op_mode == 2'b10 && reg_xcvr_sel == 2'b00));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_req && chirp_tx_en));

    assert_chirp_len_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(chirp_tx_en) |-> (chirp_ticks >= CHIRP_K_US));

    assert_hs_fields_R5: assert property (@(posedge clk) disable iff (rst)
        speed_hs |-> (reg_term_sel == 1'b0 && reg_op_mode == 2'b00 && reg_xcvr_sel == 2'b00));

    assert_hs_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        speed_hs |=> speed_hs);

    assert_hs_entry_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(speed_hs) |-> $past(reg_wr_req && reg_ack && !reg_term_sel));

    assert_fs_only_R8: assert property (@(posedge clk) disable iff (rst)
        (HS_CAPABLE == 1'b0) |-> (!reg_wr_req && !chirp_tx_en && !speed_hs));
endmodule

bind chirp_seq chirp_seq_checker #(
    .HS_CAPABLE(HS_CAPABLE),
    .CHIRP_K_US(CHIRP_K_US)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .us_tick     (us_tick),
    .reg_ack     (reg_ack),
    .reg_wr_req  (reg_wr_req),
    .reg_xcvr_sel(reg_xcvr_sel),
    .reg_term_sel(reg_term_sel),
    .reg_op_mode (reg_op_mode),
    .chirp_tx_en (chirp_tx_en),
    .speed_hs    (speed_hs)
);

// File: tb/chirp_seq_bench.sv
module chirp_seq_bench;
    localparam int SE0_MIN = 3;
    localparam int CHIRP_L = 20;
    localparam int WAIT_L  = 30;
    localparam int PAIRS   = 3;

    localparam int NV = 5;
    // stimulus: cycle (from WAIT entry) of first host K, -1 = no host chirps
    localparam int VEC_START[NV] = '{0, 10, WAIT_L - 6, WAIT_L - 5, -1};
    localparam int VEC_ACKD [NV] = '{0, 2, 1, 3, 0};
    localparam int VEC_HS   [NV] = '{1, 1, 1, 0, 0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] line_state = 2'b01;
    logic us_tick = 1'b1;
    logic reg_ack = 1'b0;
    logic reg_wr_req, reg_term_sel, chirp_tx_en, speed_hs;
    logic [1:0] reg_xcvr_sel, reg_op_mode;
    logic n_req, n_term, n_chirp, n_hs;
    logic [1:0] n_xcvr, n_opm;

    int checks = 0;
    int errors = 0;
    bit nohs_bad = 1'b0;

    always #10 clk = ~clk;

    chirp_seq #(.HS_CAPABLE(1'b1), .SE0_MIN_US(SE0_MIN), .CHIRP_K_US(CHIRP_L),
                .HOST_WAIT_US(WAIT_L), .KJ_PAIRS(PAIRS)) u_chirp_seq (
        .clk(clk), .rst(rst), .line_state(line_state), .us_tick(us_tick),
        .reg_ack(reg_ack), .reg_wr_req(reg_wr_req), .reg_xcvr_sel(reg_xcvr_sel),
        .reg_term_sel(reg_term_sel), .reg_op_mode(reg_op_mode),
        .chirp_tx_en(chirp_tx_en), .speed_hs(speed_hs));

    chirp_seq #(.HS_CAPABLE(1'b0), .SE0_MIN_US(SE0_MIN), .CHIRP_K_US(CHIRP_L),
                .HOST_WAIT_US(WAIT_L), .KJ_PAIRS(PAIRS)) u_chirp_seq_nohs (
        .clk(clk), .rst(rst), .line_state(line_state), .us_tick(us_tick),
        .reg_ack(reg_ack), .reg_wr_req(n_req), .reg_xcvr_sel(n_xcvr),
        .reg_term_sel(n_term), .reg_op_mode(n_opm),
        .chirp_tx_en(n_chirp), .speed_hs(n_hs));

    always @(negedge clk) begin
        if (!rst && (n_req || n_chirp || n_hs)) nohs_bad = 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int fields();
        return {27'd0, reg_xcvr_sel, reg_term_sel, reg_op_mode};
    endfunction

    // packed {xcvr,term,opmode}
    localparam int F_FS    = 5'b01100;
    localparam int F_CHIRP = 5'b00110;
    localparam int F_HS    = 5'b00000;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        line_state = 2'b01;
        reg_ack = 1'b0;
        us_tick = 1'b1;
        repeat (2) step();
        check(!reg_wr_req && !chirp_tx_en && !speed_hs && fields() == F_FS,
              "R1 in reset", fields(), F_FS);
        rst = 1'b0;
        step();
        check(!reg_wr_req && !chirp_tx_en && !speed_hs && fields() == F_FS,
              "R1 after reset", {reg_wr_req, chirp_tx_en, speed_hs}, 0);
    endtask

    task automatic pulse_ack();
        reg_ack = 1'b1;
        step();
        reg_ack = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step();
        for (int v = 0; v < NV; v++) begin
            int n;
            int clen;
            int s;
            int want;
            s = VEC_START[v];
            do_reset();
            repeat (3) step();
            line_state = 2'b00;
            n = 0;
            while (!reg_wr_req && n < 50) begin
                step();
                n++;
            end
            check(reg_wr_req && n >= SE0_MIN, "R2 reset qualified", n, SE0_MIN);
            check(fields() == F_CHIRP, "R3 chirp cfg fields", fields(), F_CHIRP);
            for (int d = 0; d < VEC_ACKD[v]; d++) begin
                step();
                check(reg_wr_req && fields() == F_CHIRP && !chirp_tx_en,
                      "R3 held until ack", fields(), F_CHIRP);
            end
            line_state = 2'b10;
            pulse_ack();
            clen = 0;
            while (chirp_tx_en && clen < 1000) begin
                if (reg_wr_req) check(1'b0, "R4 request during chirp", 1, 0);
                clen++;
                step();
            end
            check(clen >= CHIRP_L && clen <= CHIRP_L + 1, "R4 chirp length", clen, CHIRP_L);
            for (int k = 0; k <= WAIT_L + 2; k++) begin
                if (s >= 0 && k >= s && k < s + 2 * PAIRS)
                    line_state = ((k - s) % 2 == 0) ? 2'b10 : 2'b01;
                else
                    line_state = 2'b00;
                step();
            end
            line_state = 2'b00;
            want = VEC_HS[v] ? F_HS : F_FS;
            check(reg_wr_req && fields() == want,
                  (s == WAIT_L - 6) ? "R7 same-cycle result" : (VEC_HS[v] ? "R5 hs cfg" : "R6 fs cfg"),
                  fields(), want);
            pulse_ack();
            check(speed_hs == VEC_HS[v[2:0] == 3'd0 ? 0 : v] && !reg_wr_req,
                  VEC_HS[v] ? "R5 speed hs" : "R6 speed fs", speed_hs, VEC_HS[v]);
            if (VEC_HS[v] == 0) begin
                n = 0;
                repeat (10) begin
                    step();
                    if (reg_wr_req || chirp_tx_en) n++;
                end
                check(n == 0, "R6 no rechirp during SE0", n, 0);
            end else begin
                line_state = 2'b01;
                repeat (5) step();
                check(speed_hs == 1'b1, "R5 hs sticky", speed_hs, 1);
            end
        end

        // R2: short SE0 glitch is ignored
        do_reset();
        line_state = 2'b00;
        repeat (SE0_MIN - 1) step();
        line_state = 2'b01;
        repeat (6) step();
        check(!reg_wr_req && !chirp_tx_en, "R2 short SE0 ignored", reg_wr_req, 0);

        // R2: SE0 without ticks does not qualify
        us_tick = 1'b0;
        line_state = 2'b00;
        repeat (12) step();
        check(!reg_wr_req, "R2 no ticks no reset", reg_wr_req, 0);
        us_tick = 1'b1;
        repeat (SE0_MIN + 2) step();
        check(reg_wr_req && fields() == F_CHIRP, "R2 ticks resume qualifies", fields(), F_CHIRP);

        check(!nohs_bad, "R8 fs-only instance silent", nohs_bad, 0);
        check(n_xcvr == 2'b01 && n_term && n_opm == 2'b00, "R8 fs-only fields",
              {n_xcvr, n_term, n_opm}, F_FS);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule